// File: doc/BRIEF.md
# SDRAM Operating-Mode Register with Word Validation

This block holds the operating mode of a two-bank synchronous DRAM: burst length, burst ordering, read (CAS) latency and the write-burst length. It watches the command strobes on every rising clock edge. When row strobe, column strobe and write enable are all low, it treats the edge as a load-mode command and checks the 12-bit address word. The register changes only when the word is a legal combination and no bank is open. Any other load attempt leaves every stored field as it was and raises a one-cycle rejection pulse.

The decoded fields come straight from flops, so the rest of the controller can use them directly. A small state machine tracks the result of the last edge. `ST_IDLE` means no load command was seen. `ST_APPLIED` means a load was accepted and the fields were updated. `ST_REJECTED` means a load was refused. Every state can move to any of the three on the next edge, and the move depends only on that edge's command, bank flags and word check. The rejection pulse is high exactly while the machine is in `ST_REJECTED`.

Top module: `sdr_mode_reg`

## Requirements
- R1: After reset the outputs are burst length 1, sequential order (interleave flag 0), CAS latency 2, write-burst length 1 (equal to burst length), and the reject pulse is 0.
- R2: A load command is taken only on an edge where ras_n, cas_n and we_n are all 0. Any other strobe combination changes no field and raises no pulse.
- R3: Address bits [2:0] set the burst length: 000 gives 1, 001 gives 2, 010 gives 4, 011 gives 8. Codes 1xx are illegal.
- R4: Address bit [3] sets the burst order: 0 gives sequential (interleave flag 0), 1 gives interleaved (interleave flag 1).
- R5: Address bits [6:4] set the CAS latency: 001 gives 1, 010 gives 2, 011 gives 3. Codes 000 and 1xx are illegal.
- R6: When address bit [9] is 1, the write-burst length is 1. When it is 0, the write-burst length equals the newly loaded burst length.
- R7: A word is illegal if bit 7 or bit 8 is 1, or if it has an illegal burst-length or latency code. An illegal word leaves all fields unchanged.
- R8: A load command on an edge where any bank-active flag is 1 leaves all fields unchanged, even if the word is legal.
- R9: Address bits [11:10] have no effect on the stored fields or on accept/reject.
- R10: Each refused load command (R7 or R8) raises the reject pulse for exactly the one cycle after its edge. Accepted loads and non-load edges leave the pulse low.
- R11: Fields loaded by an accepted command appear on the outputs in the cycle right after the command edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 12 | Mode word on the address bus |
| bank_active | input | 2 | One flag per bank, 1 = bank has an open row |
| burst_len_o | output | 4 | Burst length as a count (1, 2, 4 or 8) |
| interleave_o | output | 1 | Burst order, 1 = interleaved |
| cas_lat_o | output | 2 | CAS latency in cycles (1 to 3) |
| wr_burst_len_o | output | 4 | Write-burst length as a count |
| set_reject_o | output | 1 | One-cycle pulse after a refused load |

## Verification
The two refusal causes can occur on the same edge: an open bank and an illegal word. The bench presents a word with an illegal burst-length code while both bank flags are high. The result is judged correct only if it gives a single one-cycle pulse and no field change, so the two causes must merge into one event. Back-to-back refusals are also applied, followed by an accepted load. This confirms that the pulse stays high across consecutive refused edges and drops on the edge where the new fields appear.

// File: rtl/sdr_mode_pkg.sv
package sdr_mode_pkg;

    // Field widths and bit positions of the mode word
    localparam int ADDR_W      = 12;
    localparam int BL_W        = 4;
    localparam int CL_W        = 2;
    localparam int BL_LSB      = 0;
    localparam int BL_CODE_W   = 3;
    localparam int BT_BIT      = 3;
    localparam int CL_LSB      = 4;
    localparam int CL_CODE_W   = 3;
    localparam int RSV_LO      = 7;
    localparam int RSV_HI      = 8;
    localparam int WSINGLE_BIT = 9;
    localparam int IGN_LO      = 10;

    typedef enum logic {
        BURST_SEQ = 1'b0,
        BURST_ILV = 1'b1
    } burst_kind_e;

    typedef struct packed {
        logic [BL_W-1:0] blen;
        burst_kind_e     bkind;
        logic [CL_W-1:0] clat;
        logic            wr_single;
    } mode_fields_t;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_APPLIED  = 2'd1,
        ST_REJECTED = 2'd2
    } load_state_e;

    localparam mode_fields_t RESET_FIELDS = '{
        blen:      BL_W'(1),
        bkind:     BURST_SEQ,
        clat:      CL_W'(2),
        wr_single: 1'b0
    };

endpackage

// File: rtl/sdr_mode_cmd_detect.sv
module sdr_mode_cmd_detect #(
    parameter int NUM_BANKS = 2
) (
    input  logic                 ras_n,
    input  logic                 cas_n,
    input  logic                 we_n,
    input  logic [NUM_BANKS-1:0] bank_active,
    output logic                 set_seen_o,
    output logic                 banks_idle_o
);

    logic [NUM_BANKS-1:0] open_acc;

    // Fold bank flags one stage per bank
    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            if (b == 0) begin : g_first
                assign open_acc[b] = bank_active[b];
            end else begin : g_rest
                assign open_acc[b] = open_acc[b-1] | bank_active[b];
            end
        end
    endgenerate

    always_comb begin
        set_seen_o   = ~ras_n & ~cas_n & ~we_n;
        banks_idle_o = ~open_acc[NUM_BANKS-1];
    end

endmodule

// File: rtl/sdr_mode_word_check.sv
module sdr_mode_word_check
    import sdr_mode_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    output mode_fields_t      cand_o,
    output logic              word_ok_o
);

    localparam int RSV_N = RSV_HI - RSV_LO + 1;

    logic [BL_CODE_W-1:0] bl_code;
    logic [CL_CODE_W-1:0] cl_code;
    logic [RSV_N-1:0]     rsv_bits;
    logic                 bl_ok;
    logic                 cl_ok;
    logic                 rsv_ok;
    logic                 unused_hi_bits;

    assign bl_code = addr_i[BL_LSB +: BL_CODE_W];
    assign cl_code = addr_i[CL_LSB +: CL_CODE_W];

    // Reserved bits that must be zero
    generate
        for (genvar r = 0; r < RSV_N; r++) begin : g_rsv
            assign rsv_bits[r] = addr_i[RSV_LO + r];
        end
    endgenerate

    // Top bits are don't-care
    assign unused_hi_bits = ^addr_i[ADDR_W-1:IGN_LO];

    always_comb begin
        bl_ok  = ~bl_code[BL_CODE_W-1];
        cl_ok  = ~cl_code[CL_CODE_W-1] & (cl_code != '0);
        rsv_ok = (rsv_bits == '0);
        word_ok_o = bl_ok & cl_ok & rsv_ok;

        cand_o.blen      = BL_W'(1) << bl_code[1:0];
        cand_o.bkind     = addr_i[BT_BIT] ? BURST_ILV : BURST_SEQ;
        cand_o.clat      = cl_code[CL_W-1:0];
        cand_o.wr_single = addr_i[WSINGLE_BIT];
    end

endmodule

// File: rtl/sdr_mode_ctrl.sv
module sdr_mode_ctrl
    import sdr_mode_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_seen_i,
    input  logic            banks_idle_i,
    input  logic            word_ok_i,
    input  mode_fields_t    cand_i,
    output logic [BL_W-1:0] burst_len_o,
    output logic            interleave_o,
    output logic [CL_W-1:0] cas_lat_o,
    output logic [BL_W-1:0] wr_burst_len_o,
    output logic            set_reject_o
);

    load_state_e  state_q;
    load_state_e  state_d;
    mode_fields_t fields_q;

    // Next-state decision
    always_comb begin
        state_d = ST_IDLE;
        if (set_seen_i) begin
            if (banks_idle_i && word_ok_i) begin
                state_d = ST_APPLIED;
            end else begin
                state_d = ST_REJECTED;
            end
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Field storage, loaded on the transition into ST_APPLIED
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fields_q <= RESET_FIELDS;
        end else if (state_d == ST_APPLIED) begin
            fields_q <= cand_i;
        end
    end

    // Outputs
    always_comb begin
        burst_len_o    = fields_q.blen;
        interleave_o   = (fields_q.bkind == BURST_ILV);
        cas_lat_o      = fields_q.clat;
        wr_burst_len_o = fields_q.wr_single ? BL_W'(1) : fields_q.blen;
        set_reject_o   = 1'b0;
        unique case (state_q)
            ST_IDLE:     set_reject_o = 1'b0;
            ST_APPLIED:  set_reject_o = 1'b0;
            ST_REJECTED: set_reject_o = 1'b1;
            default:     set_reject_o = 1'b0;
        endcase
    end

    // R2
    fields_need_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fields_q) |-> $past(set_seen_i));

    // R7
    reject_keeps_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_reject_o |-> ($stable(burst_len_o) && $stable(interleave_o)
                          && $stable(cas_lat_o) && $stable(wr_burst_len_o)));

    // R8
    open_bank_rejects_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_seen_i && !banks_idle_i) |=> set_reject_o);

    // R10
    reject_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_reject_o |-> $past(set_seen_i && !(banks_idle_i && word_ok_i)));

    // R3
    blen_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(burst_len_o) == 1) && (burst_len_o <= BL_W'(8)));

    // R5
    clat_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cas_lat_o != '0);

    // R6
    wr_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_burst_len_o != burst_len_o) |-> (wr_burst_len_o == BL_W'(1)));

endmodule

// File: rtl/sdr_mode_reg.sv
module sdr_mode_reg
    import sdr_mode_pkg::*;
#(
    parameter int NUM_BANKS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ras_n,
    input  logic                 cas_n,
    input  logic                 we_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [NUM_BANKS-1:0] bank_active,
    output logic [BL_W-1:0]      burst_len_o,
    output logic                 interleave_o,
    output logic [CL_W-1:0]      cas_lat_o,
    output logic [BL_W-1:0]      wr_burst_len_o,
    output logic                 set_reject_o
);

    logic         set_seen;
    logic         banks_idle;
    logic         word_ok;
    mode_fields_t cand;

    sdr_mode_cmd_detect #(
        .NUM_BANKS (NUM_BANKS)
    ) cmd_i (
        .ras_n        (ras_n),
        .cas_n        (cas_n),
        .we_n         (we_n),
        .bank_active  (bank_active),
        .set_seen_o   (set_seen),
        .banks_idle_o (banks_idle)
    );

    sdr_mode_word_check chk_i (
        .addr_i    (addr),
        .cand_o    (cand),
        .word_ok_o (word_ok)
    );

    sdr_mode_ctrl ctrl_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .set_seen_i     (set_seen),
        .banks_idle_i   (banks_idle),
        .word_ok_i      (word_ok),
        .cand_i         (cand),
        .burst_len_o    (burst_len_o),
        .interleave_o   (interleave_o),
        .cas_lat_o      (cas_lat_o),
        .wr_burst_len_o (wr_burst_len_o),
        .set_reject_o   (set_reject_o)
    );

    // R4
    ilv_follows_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_seen && banks_idle && word_ok) |=> (interleave_o == $past(addr[3])));

endmodule

// File: tb/sdr_mode_reg_tb_top.sv
module sdr_mode_reg_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ras_n = 1'b1;
    logic        cas_n = 1'b1;
    logic        we_n = 1'b1;
    logic [11:0] addr = '0;
    logic [1:0]  bank_active = '0;
    logic [3:0]  burst_len_o;
    logic        interleave_o;
    logic [1:0]  cas_lat_o;
    logic [3:0]  wr_burst_len_o;
    logic        set_reject_o;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;  // 250 MHz

    sdr_mode_reg dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .ras_n          (ras_n),
        .cas_n          (cas_n),
        .we_n           (we_n),
        .addr           (addr),
        .bank_active    (bank_active),
        .burst_len_o    (burst_len_o),
        .interleave_o   (interleave_o),
        .cas_lat_o      (cas_lat_o),
        .wr_burst_len_o (wr_burst_len_o),
        .set_reject_o   (set_reject_o)
    );

    // Vector: {ras,cas,we, banks, addr, exp_bl, exp_ilv, exp_cl, exp_wbl, exp_rej}
    localparam int NV = 21;
    localparam logic [28:0] VEC [NV] = '{
        {3'b000, 2'b00, 12'h032, 4'd4, 1'b0, 2'd3, 4'd4, 1'b0}, // R3 R5 R11 load
        {3'b000, 2'b00, 12'h21B, 4'd8, 1'b1, 2'd1, 4'd1, 1'b0}, // R4 R6 load
        {3'b000, 2'b00, 12'h024, 4'd8, 1'b1, 2'd1, 4'd1, 1'b1}, // R7 bl code 100
        {3'b000, 2'b00, 12'h001, 4'd8, 1'b1, 2'd1, 4'd1, 1'b1}, // R7 cl code 000
        {3'b000, 2'b00, 12'h041, 4'd8, 1'b1, 2'd1, 4'd1, 1'b1}, // R7 cl code 100
        {3'b000, 2'b00, 12'h091, 4'd8, 1'b1, 2'd1, 4'd1, 1'b1}, // R7 bit 7 set
        {3'b000, 2'b00, 12'h111, 4'd8, 1'b1, 2'd1, 4'd1, 1'b1}, // R7 bit 8 set
        {3'b000, 2'b01, 12'h021, 4'd8, 1'b1, 2'd1, 4'd1, 1'b1}, // R8 bank 0 open
        {3'b000, 2'b10, 12'h021, 4'd8, 1'b1, 2'd1, 4'd1, 1'b1}, // R8 bank 1 open
        {3'b001, 2'b00, 12'h021, 4'd8, 1'b1, 2'd1, 4'd1, 1'b0}, // R2 we high
        {3'b011, 2'b00, 12'h021, 4'd8, 1'b1, 2'd1, 4'd1, 1'b0}, // R2 cas we high
        {3'b111, 2'b00, 12'h021, 4'd8, 1'b1, 2'd1, 4'd1, 1'b0}, // R2 nop
        {3'b000, 2'b00, 12'hC21, 4'd2, 1'b0, 2'd2, 4'd2, 1'b0}, // R9 top bits set
        {3'b000, 2'b00, 12'h000, 4'd2, 1'b0, 2'd2, 4'd2, 1'b1}, // R7 all zero
        {3'b000, 2'b00, 12'h030, 4'd1, 1'b0, 2'd3, 4'd1, 1'b0}, // R3 R6 length 1
        {3'b000, 2'b11, 12'h007, 4'd1, 1'b0, 2'd3, 4'd1, 1'b1}, // R8 R7 both causes
        {3'b000, 2'b00, 12'h22A, 4'd4, 1'b1, 2'd2, 4'd1, 1'b0}, // R10 pulse drops on accept
        {3'b000, 2'b00, 12'h013, 4'd8, 1'b0, 2'd1, 4'd8, 1'b0}, // R6 follows length
        {3'b000, 2'b00, 12'h017, 4'd8, 1'b0, 2'd1, 4'd8, 1'b1}, // R3 bl code 111
        {3'b110, 2'b00, 12'h022, 4'd8, 1'b0, 2'd1, 4'd8, 1'b0}, // R2 ras only
        {3'b100, 2'b00, 12'h022, 4'd8, 1'b0, 2'd1, 4'd8, 1'b0}  // R2 ras high
    };

    task automatic check_out(input string tag, input logic [3:0] bl, input logic ilv,
                             input logic [1:0] cl, input logic [3:0] wbl, input logic rej);
        checks++;
        if (burst_len_o !== bl || interleave_o !== ilv || cas_lat_o !== cl ||
            wr_burst_len_o !== wbl || set_reject_o !== rej) begin
            failures++;
            $display("FAIL %s actual bl=%0d ilv=%0b cl=%0d wbl=%0d rej=%0b expected bl=%0d ilv=%0b cl=%0d wbl=%0d rej=%0b",
                     tag, burst_len_o, interleave_o, cas_lat_o, wr_burst_len_o, set_reject_o,
                     bl, ilv, cl, wbl, rej);
        end
    endtask

    task automatic drive(input logic [2:0] cmd, input logic [1:0] bk, input logic [11:0] a);
        {ras_n, cas_n, we_n} = cmd;
        bank_active = bk;
        addr = a;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_out("R1 reset values", 4'd1, 1'b0, 2'd2, 4'd1, 1'b0);

        // Table walk: drive at falling edge, sample at the next falling edge
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][28:26], VEC[i][25:24], VEC[i][23:12]);
            @(negedge clk);
            check_out($sformatf("table vec%0d (R2-R11 see row comment)", i),
                      VEC[i][11:8], VEC[i][7], VEC[i][6:5], VEC[i][4:1], VEC[i][0]);
        end

        // R10: single refusal followed by a nop, pulse lasts one cycle
        drive(3'b000, 2'b00, 12'h0A1);
        @(negedge clk);
        check_out("R10 pulse high", 4'd8, 1'b0, 2'd1, 4'd8, 1'b1);
        drive(3'b111, 2'b00, 12'h0A1);
        @(negedge clk);
        check_out("R10 pulse gone", 4'd8, 1'b0, 2'd1, 4'd8, 1'b0);

        // R9: top bits alone differ, same accept and same fields
        drive(3'b000, 2'b00, 12'h83B);
        @(negedge clk);
        check_out("R9 top bit 11", 4'd8, 1'b1, 2'd3, 4'd8, 1'b0);
        drive(3'b000, 2'b00, 12'h43B);
        @(negedge clk);
        check_out("R9 top bit 10", 4'd8, 1'b1, 2'd3, 4'd8, 1'b0);

        // R11: update visible exactly one cycle later, not before
        drive(3'b000, 2'b00, 12'h021);
        #1;
        check_out("R11 not yet", 4'd8, 1'b1, 2'd3, 4'd8, 1'b0);
        @(negedge clk);
        check_out("R11 loaded", 4'd2, 1'b0, 2'd2, 4'd2, 1'b0);

        // R1: reset in the middle of operation
        drive(3'b111, 2'b00, 12'h000);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_out("R1 reset again", 4'd1, 1'b0, 2'd2, 4'd1, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule